// File: doc/BRIEF.md
# Event and Cycle Performance Counter Block

This block counts clock cycles and two kinds of selectable events so that software can measure how a processor or a subsystem behaves over a window of time. It holds one 32-bit cycle counter, two 32-bit event counters and a single 32-bit control word. The control word carries the global run bit, the two self-clearing counter reset commands, a slow-clock mode for the cycle counter, three interrupt enables, three overflow flags and the two 8-bit event codes.

Each clock, the block receives a bundle of one-bit event strobes. The 8-bit code of an event counter picks the strobe that counter follows. Code 0xFF, and any code that does not name a strobe in the bundle, selects nothing. Software reaches the control word and the three counters through a small register port with a 2-bit address, a write strobe, write data and a combinational read path. A counter that wraps from all ones to zero sets its overflow flag. The interrupt output stays high while any flag is set whose interrupt enable is also set.

Top module: `perfmon_unit`

## Requirements
- R1: After reset the control word reads 0x0FFFF000: both event codes are 0xFF and every other bit is 0. All three counters read 0 and irq is 0.
- R2: Control word layout: bit 0 is the run bit, bit 3 is slow mode, bits 4, 5 and 6 are the interrupt enables for event counter 0, event counter 1 and the cycle counter, bits 19:12 are the event code of counter 0, and bits 27:20 are the event code of counter 1. Written values read back in those positions. Bits 31:28, 11, 7, 2 and 1 always read 0.
- R3: Address 0 is the control word, address 1 the cycle counter, address 2 event counter 0 and address 3 event counter 1. A write to a counter address loads the value even while the run bit is 0. Loading 0xFFFFFFFF does not set a flag.
- R4: With the run bit set and slow mode off, the cycle counter increases by one on every clock edge.
- R5: In slow mode the cycle counter increases once per 64 clocks counted while running. The divider holds while the run bit is 0, and it is cleared by the cycle counter reset command.
- R6: With the run bit set, an event counter increases by one on each clock edge where the strobe named by its code is 1.
- R7: An event counter whose code is 0xFF, or names no strobe (code of 32 or more), never increases.
- R8: While the run bit is 0 no counter advances, whatever the strobes do.
- R9: Writing the control word with bit 1 set zeroes both event counters on that clock edge. Writing it with bit 2 set zeroes the cycle counter on that clock edge. Neither bit is stored.
- R10: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag: bit 10 for the cycle counter, bit 8 for event counter 0 and bit 9 for event counter 1. Writing 1 to a flag bit clears it, and writing 0 leaves it. A wrap in the same clock as a clear leaves the flag set.
- R11: irq is 1 exactly while some overflow flag and its own interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_strobe | input | NUM_STROBES (32) | Per-clock event strobes |
| irq | output | 1 | Level interrupt |

## Verification
The cycle counter is run for a known number of clocks in plain mode. In slow mode it is run for one clock short of the third divider tick, and the divider is then shown to keep its phase while stopped. Together these separate an off-by-one in the run window from a divider that restarts or counts while idle. The event counters are driven by a changing strobe pattern that follows two different codes at once. The pattern shows whether each counter follows only its own strobe. A null code and an out-of-range code face an all-ones bundle, and a stopped block faces a busy one; both show that no count leaks. Wraps are made on an event counter with its interrupt enabled and on the cycle counter with its enable off. These runs show that flags are set, that write-one-to-clear and write-zero-to-keep work, and that irq is gated per counter.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int DATA_W  = 32;
    localparam int SEL_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_CNT = 3;

    // counter slot order inside packed vectors
    localparam int SLOT_CYC = 0;
    localparam int SLOT_EV0 = 1;
    localparam int SLOT_EV1 = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CYC  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_EV0  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_EV1  = 2'd3;

    localparam logic [SEL_W-1:0] CODE_NONE = 8'hFF;

    // control word bit positions
    localparam int B_RUN     = 0;
    localparam int B_CLR_EV  = 1;
    localparam int B_CLR_CY  = 2;
    localparam int B_SLOW    = 3;
    localparam int B_IE_EV0  = 4;
    localparam int B_IE_EV1  = 5;
    localparam int B_IE_CY   = 6;
    localparam int B_OV_EV0  = 8;
    localparam int B_OV_EV1  = 9;
    localparam int B_OV_CY   = 10;
    localparam int SEL0_LSB  = 12;
    localparam int SEL1_LSB  = 20;

    typedef struct packed {
        logic                      run;
        logic                      slow;
        logic [NUM_CNT-1:0]        irq_en;
        logic [NUM_CNT-1:0]        ovf;
        logic [1:0][SEL_W-1:0]     sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        run:    1'b0,
        slow:   1'b0,
        irq_en: '0,
        ovf:    '0,
        sel:    {CODE_NONE, CODE_NONE}
    };

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w                              = '0;
        w[B_RUN]                       = c.run;
        w[B_SLOW]                      = c.slow;
        w[B_IE_CY]                     = c.irq_en[SLOT_CYC];
        w[B_IE_EV0]                    = c.irq_en[SLOT_EV0];
        w[B_IE_EV1]                    = c.irq_en[SLOT_EV1];
        w[B_OV_CY]                     = c.ovf[SLOT_CYC];
        w[B_OV_EV0]                    = c.ovf[SLOT_EV0];
        w[B_OV_EV1]                    = c.ovf[SLOT_EV1];
        w[SEL0_LSB +: SEL_W]           = c.sel[0];
        w[SEL1_LSB +: SEL_W]           = c.sel[1];
        return w;
    endfunction

    function automatic logic [NUM_CNT-1:0] ovf_bits(input logic [DATA_W-1:0] w);
        logic [NUM_CNT-1:0] m;
        m[SLOT_CYC] = w[B_OV_CY];
        m[SLOT_EV0] = w[B_OV_EV0];
        m[SLOT_EV1] = w[B_OV_EV1];
        return m;
    endfunction

    function automatic logic [NUM_CNT-1:0] ie_bits(input logic [DATA_W-1:0] w);
        logic [NUM_CNT-1:0] m;
        m[SLOT_CYC] = w[B_IE_CY];
        m[SLOT_EV0] = w[B_IE_EV0];
        m[SLOT_EV1] = w[B_IE_EV1];
        return m;
    endfunction

endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_CNT-1:0]  wrap,
    output ctrl_t               ctrl,
    output logic                clr_evt,
    output logic                clr_cyc
);

    ctrl_t              ctrl_q;
    logic [NUM_CNT-1:0] clr_mask;
    logic               unused_bits;

    assign unused_bits = ^{wdata[DATA_W-1:28], wdata[11], wdata[7]};

    assign clr_evt  = wr & wdata[B_CLR_EV];
    assign clr_cyc  = wr & wdata[B_CLR_CY];
    assign clr_mask = wr ? ovf_bits(wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            if (wr) begin
                ctrl_q.run    <= wdata[B_RUN];
                ctrl_q.slow   <= wdata[B_SLOW];
                ctrl_q.irq_en <= ie_bits(wdata);
                ctrl_q.sel[0] <= wdata[SEL0_LSB +: SEL_W];
                ctrl_q.sel[1] <= wdata[SEL1_LSB +: SEL_W];
            end
            // a wrap in the same clock as a clear keeps the flag
            ctrl_q.ovf <= (ctrl_q.ovf & ~clr_mask) | wrap;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/perfmon_prescale.sv
module perfmon_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);

    localparam int PS_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(DIV - 1);

    logic [PS_W-1:0] ps_q;

    assign tick = run && (ps_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ps_q <= '0;
        end else if (run) begin
            ps_q <= (ps_q == LAST) ? '0 : ps_q + 1'b1;
        end
    end

endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel
    import perfmon_pkg::*;
#(
    parameter int NUM_STROBES = 32
) (
    input  logic [SEL_W-1:0]       code,
    input  logic [NUM_STROBES-1:0] strobes,
    output logic                   hit
);

    always_comb begin
        hit = 1'b0;
        if (code != CODE_NONE) begin
            for (int i = 0; i < NUM_STROBES; i++) begin
                if (code == SEL_W'(i)) hit = strobes[i];
            end
        end
    end

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              inc,
    output logic [DATA_W-1:0] count,
    output logic              wrap
);

    logic [DATA_W-1:0] cnt_q;

    assign wrap  = inc && !clr && !ld && (cnt_q == '1);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int NUM_STROBES = 32,
    parameter int SLOW_DIV    = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NUM_STROBES-1:0] evt_strobe,
    output logic                   irq
);

    ctrl_t                          ctrl_q;
    logic                           clr_evt;
    logic                           clr_cyc;
    logic                           slow_tick;
    logic [1:0]                     ev_hit;
    logic [NUM_CNT-1:0]             inc;
    logic [NUM_CNT-1:0]             clr;
    logic [NUM_CNT-1:0]             ld;
    logic [NUM_CNT-1:0]             wrap_q;
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q;

    perfmon_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_we && bus_addr == ADR_CTRL),
        .wdata   (bus_wdata),
        .wrap    (wrap_q),
        .ctrl    (ctrl_q),
        .clr_evt (clr_evt),
        .clr_cyc (clr_cyc)
    );

    perfmon_prescale #(.DIV(SLOW_DIV)) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_cyc),
        .run  (ctrl_q.run),
        .tick (slow_tick)
    );

    for (genvar e = 0; e < 2; e++) begin : g_evsel
        perfmon_evsel #(.NUM_STROBES(NUM_STROBES)) u_evsel (
            .code    (ctrl_q.sel[e]),
            .strobes (evt_strobe),
            .hit     (ev_hit[e])
        );
    end

    assign inc[SLOT_CYC] = ctrl_q.run && (!ctrl_q.slow || slow_tick);
    assign inc[SLOT_EV0] = ctrl_q.run && ev_hit[0];
    assign inc[SLOT_EV1] = ctrl_q.run && ev_hit[1];

    assign clr[SLOT_CYC] = clr_cyc;
    assign clr[SLOT_EV0] = clr_evt;
    assign clr[SLOT_EV1] = clr_evt;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign ld[g] = bus_we && (bus_addr == ADDR_W'(g + 1));

        perfmon_counter u_counter (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr[g]),
            .ld     (ld[g]),
            .ld_val (bus_wdata),
            .inc    (inc[g]),
            .count  (cnt_q[g]),
            .wrap   (wrap_q[g])
        );
    end

    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = pack_ctrl(ctrl_q);
            ADR_CYC:  bus_rdata = cnt_q[SLOT_CYC];
            ADR_EV0:  bus_rdata = cnt_q[SLOT_EV0];
            default:  bus_rdata = cnt_q[SLOT_EV1];
        endcase
    end

    assign irq = |(ctrl_q.ovf & ctrl_q.irq_en);

endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker
    import perfmon_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic [DATA_W-1:0]              bus_rdata,
    input  logic                           irq,
    input  ctrl_t                          ctrl,
    input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt,
    input  logic [NUM_CNT-1:0]             wrap
);

    assert_ctrl_zero_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_CTRL) |-> ((bus_rdata & 32'hF000_0886) == '0));

    assert_null_code_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel[1] == CODE_NONE && !bus_we) |=> $stable(cnt[SLOT_EV1]));

    assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !bus_we) |=> $stable(cnt));

    assert_event_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_CTRL && bus_wdata[B_CLR_EV])
        |=> (cnt[SLOT_EV0] == '0 && cnt[SLOT_EV1] == '0));

    assert_cycle_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_CTRL && bus_wdata[B_CLR_CY])
        |=> (cnt[SLOT_CYC] == '0));

    assert_wrap_cyc_flag_R10: assert property (@(posedge clk) disable iff (rst)
        wrap[SLOT_CYC] |=> ctrl.ovf[SLOT_CYC]);

    assert_wrap_ev0_flag_R10: assert property (@(posedge clk) disable iff (rst)
        wrap[SLOT_EV0] |=> ctrl.ovf[SLOT_EV0]);

    assert_wrap_ev1_flag_R10: assert property (@(posedge clk) disable iff (rst)
        wrap[SLOT_EV1] |=> ctrl.ovf[SLOT_EV1]);

    assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.ovf != '0));

endmodule

bind perfmon_unit perfmon_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl      (ctrl_q),
    .cnt       (cnt_q),
    .wrap      (wrap_q)
);

// File: tb/test_perfmon_unit.sv
`timescale 1ns/1ps
module test_perfmon_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_strobe = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    perfmon_unit i_perfmon_unit (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    // every task is entered and left at a falling edge
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0FFF_F000);
        rd(2'd1, v); chk("R1 cyc", v, 32'h0);
        rd(2'd2, v); chk("R1 ev0", v, 32'h0);
        rd(2'd3, v); chk("R1 ev1", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2 all ones", v, 32'h0FFF_F079);
        wr(2'd0, 32'h0A5C_3018);
        rd(2'd0, v); chk("R2 pattern", v, 32'h0A5C_3018);
        wr(2'd0, 32'hFFFF_F886);
        rd(2'd0, v); chk("R2 zero bits", v, 32'h0FFF_F000);
    endtask

    task automatic t_counters;
        logic [31:0] v;
        wr(2'd1, 32'h1111_1111);
        wr(2'd2, 32'h2222_2222);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R3 cyc load", v, 32'h1111_1111);
        rd(2'd2, v); chk("R3 ev0 load", v, 32'h2222_2222);
        rd(2'd3, v); chk("R3 ev1 load", v, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R3 no flag on load", v, 32'h0FFF_F000);
    endtask

    task automatic t_cycle;
        logic [31:0] v;
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0FFF_F001);
        repeat (9) @(negedge clk);
        wr(2'd0, 32'h0FFF_F000);
        rd(2'd1, v); chk("R4 ten clocks", v, 32'd10);
    endtask

    task automatic t_slow;
        logic [31:0] v;
        wr(2'd0, 32'h0FFF_F00D);
        repeat (190) @(negedge clk);
        wr(2'd0, 32'h0FFF_F008);
        rd(2'd1, v); chk("R5 191 clocks", v, 32'd2);
        wr(2'd0, 32'h0FFF_F009);
        wr(2'd0, 32'h0FFF_F008);
        rd(2'd1, v); chk("R5 divider kept phase", v, 32'd3);
    endtask

    task automatic t_event;
        logic [31:0] v;
        int e0 = 0;
        int e1 = 0;
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h0090_5001);
        for (int i = 0; i < 24; i++) begin
            logic [31:0] s;
            s = (i * 32'h9E37_79B9) ^ (i << 3);
            evt_strobe = s;
            e0 += s[5];
            e1 += s[9];
            @(negedge clk);
        end
        evt_strobe = '0;
        wr(2'd0, 32'h0090_5000);
        rd(2'd2, v); chk("R6 ev0 code 5", v, e0);
        rd(2'd3, v); chk("R6 ev1 code 9", v, e1);
    endtask

    task automatic t_null;
        logic [31:0] v;
        wr(2'd2, 32'd7);
        wr(2'd3, 32'd7);
        wr(2'd0, 32'h040F_F001);
        evt_strobe = '1;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        wr(2'd0, 32'h040F_F000);
        rd(2'd2, v); chk("R7 code FF", v, 32'd7);
        rd(2'd3, v); chk("R7 code 40", v, 32'd7);
    endtask

    task automatic t_freeze;
        logic [31:0] v;
        wr(2'd0, 32'h0FF0_0000);
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd5);
        evt_strobe = '1;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        rd(2'd1, v); chk("R8 cyc held", v, 32'd100);
        rd(2'd2, v); chk("R8 ev0 held", v, 32'd5);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(2'd1, 32'h55);
        wr(2'd2, 32'h66);
        wr(2'd3, 32'h77);
        wr(2'd0, 32'h0FFF_F002);
        rd(2'd2, v); chk("R9 ev0 cleared", v, 32'h0);
        rd(2'd3, v); chk("R9 ev1 cleared", v, 32'h0);
        rd(2'd1, v); chk("R9 cyc kept", v, 32'h55);
        rd(2'd0, v); chk("R9 bit not stored", v, 32'h0FFF_F000);
        wr(2'd0, 32'h0FFF_F004);
        rd(2'd1, v); chk("R9 cyc cleared", v, 32'h0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FFFE);
        wr(2'd0, 32'h0FF0_3011);
        evt_strobe = 32'h8;
        @(negedge clk);
        @(negedge clk);
        evt_strobe = '0;
        wr(2'd0, 32'h0FF0_3010);
        rd(2'd2, v); chk("R10 ev0 wrapped", v, 32'h0);
        rd(2'd0, v); chk("R10 ev0 flag", v, 32'h0FF0_3110);
        chk("R11 irq on", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0FF0_3010);
        rd(2'd0, v); chk("R10 zero keeps flag", v, 32'h0FF0_3110);
        wr(2'd0, 32'h0FF0_3110);
        rd(2'd0, v); chk("R10 one clears flag", v, 32'h0FF0_3010);
        chk("R11 irq off", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0FF0_3011);
        wr(2'd0, 32'h0FF0_3010);
        rd(2'd0, v); chk("R10 cyc flag", v, 32'h0FF0_3410);
        chk("R11 irq gated", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0FF0_3050);
        chk("R11 irq cyc enable", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0FF0_3450);
        chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fields();
        t_counters();
        t_cycle();
        t_slow();
        t_event();
        t_null();
        t_freeze();
        t_clear();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule